// File: doc/BRIEF.md
# Nibble-Serial Byte ALU Datapath

This block is the datapath of an 8-bit arithmetic unit. Its arithmetic and logic core is only four bits wide. A byte operation therefore takes two consecutive clock cycles. The first is a low pass over the low nibbles. The second is a high pass over the high nibbles.

The external sequencer handles the chaining between the passes. It captures the carry-out of the low pass as the half-carry and feeds it back in as the carry-in of the high pass. It does the same with the parity output, which goes back in as the parity input. Flag registers and instruction sequencing stay outside the block.

Around the core sit several parts:
- Two operand latches, each with its own source select.
- A result latch that is written one nibble per pass.
- An input stage that can shift the incoming byte, or produce a one-hot byte from a bit index.
- An internal byte bus with exactly one driver at a time.

The internal bus reaches a bidirectional external byte bus through a tri-state port. That port drives only while the output enable is high. When the enable is low, the shifter reads the byte that the outside places on the bus.

The block also produces decimal-adjust comparisons, overflow, zero, sign and two copied result bits. All of these are valid during the high pass.

Top module: `nibble_alu`

## Requirements
- R1: After reset, reading operand 1, operand 2 or the result latch onto the bus gives 0x00.
- R2: The block drives `extBus` with the internal bus only while `extOe` is 1. The codes for `busSrc` are:
  - 0: nothing (the bus reads 0x00)
  - 1: operand 1
  - 2: operand 2
  - 3: result latch
  - 4: shifter
  - 5: bit selector
  - 6 and 7: also read 0x00
- R3: At a clock edge, `op1Sel` loads operand 1 as follows: 0 holds it, 1 takes the bus, 2 takes {4'h0, bus[3:0]}, and 3 loads zero.
- R4: At a clock edge, `op2Sel` loads operand 2 as follows: 0 holds it, 1 takes the bus, 2 takes `altIn`, and 3 loads zero.
- R5: The shifter input x is `extBus` while `extOe` is 0, and 0x00 otherwise. The shifter output is chosen in this order:
  - If `shiftRight` is 1, the output is {shiftIn, x[7:1]}. This takes priority.
  - Otherwise, if `shiftLeft` is 1, the output is {x[6:0], shiftIn}.
  - Otherwise, the output is x.
  - `shiftBit0` always equals x[0], and `shiftBit7` always equals x[7].
- R6: The bit selector puts on the bus a byte in which only bit `bitIdx` is set.
- R7: The core operands are chosen as follows:
  - Operand A is operand 1's low nibble when `passLow` is 1, and its high nibble otherwise.
  - Operand B is operand 2's high nibble when `highSel` is 1, and its low nibble otherwise. When `negOp2` is 1, B is complemented.
  - An add gives A+B+`coreCin`, with the carry-out on `cfOut`.
  - The result low nibble is written at the end of a `passLow` cycle. The high nibble is written at the end of a `passHigh` cycle without `passLow`.
  - Adding 0x8C and 0x68 reads back 0xF4.
- R8: The operation codes are {`opS`,`opR`}: 00 add, 01 AND, 10 OR, 11 XOR. For the logic operations, `cfOut` is 0.
- R9: `vfOut` is 1 only when `opV` is 1 and the operation is an add. In that case it is the XOR of the carry into the nibble's top bit and the carry out of it. On the high pass this is signed byte overflow.
- R10: `parityOut` is 1 when `parityIn` equals the even-parity bit of the current core nibble. A low pass is driven with `parityIn` = 1, so the high-pass output is 1 exactly when the byte has an even number of ones.
- R11: The zero, sign and copied-bit flags are:
  - `zeroOut` is 1 when the stored low nibble and the current core nibble are both zero.
  - `signOut` is core bit 3 (byte bit 7).
  - `yfOut` is core bit 1 (byte bit 5).
  - `xfOut` is stored bit 3 (byte bit 3).
- R12: The decimal-adjust flags are:
  - `lowGt9` is 1 when the stored low nibble is greater than 9.
  - `highGt9` is 1 when the current core nibble is greater than 9.
  - `highEq9` is 1 when the current core nibble equals 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extBus | inout | 8 | External byte bus |
| extOe | input | 1 | Drive the internal bus onto extBus |
| busSrc | input | 3 | Internal bus source code |
| op1Sel | input | 2 | Operand 1 load source |
| op2Sel | input | 2 | Operand 2 load source |
| altIn | input | 8 | Alternate operand 2 source |
| shiftRight | input | 1 | Shift right |
| shiftLeft | input | 1 | Shift left |
| shiftIn | input | 1 | Fill bit for a shift |
| shiftBit0 | output | 1 | Incoming bit 0 |
| shiftBit7 | output | 1 | Incoming bit 7 |
| bitIdx | input | 3 | Bit selector index |
| passLow | input | 1 | Low-nibble pass |
| passHigh | input | 1 | High-nibble pass |
| highSel | input | 1 | Use operand 2 high nibble |
| negOp2 | input | 1 | Complement operand 2 nibble |
| coreCin | input | 1 | Core carry-in |
| opR | input | 1 | Operation control bit R |
| opS | input | 1 | Operation control bit S |
| opV | input | 1 | Enable overflow |
| parityIn | input | 1 | Chained parity in |
| cfOut | output | 1 | Core carry-out |
| vfOut | output | 1 | Overflow |
| parityOut | output | 1 | Chained even parity |
| zeroOut | output | 1 | Result zero |
| signOut | output | 1 | Result bit 7 |
| yfOut | output | 1 | Result bit 5 copy |
| xfOut | output | 1 | Result bit 3 copy |
| lowGt9 | output | 1 | Low nibble above 9 |
| highGt9 | output | 1 | High nibble above 9 |
| highEq9 | output | 1 | High nibble equal to 9 |

## Verification
The assertions check several properties on every cycle:
- A bit-selected byte on the bus is one-hot.
- The idle bus code reads zero.
- Logic operations never carry.
- A zero result never shows a sign or copied bit.
- The two nine-comparisons exclude each other.
- An operand 1 that is held reads back unchanged.

The arithmetic itself can only be shown by the bench's operand sweeps. These cover carry and half-carry chaining, subtraction by complement, overflow, parity chaining across the passes, and the decimal-adjust values. The shifter modes and the load sources are also shown by the bench.

// File: rtl/nibAluPkg.sv
package nibAluPkg;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = BYTE_W / 2;
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam int DEC_MAX = 9;
  localparam int YF_POS  = 5;
  localparam int XF_POS  = 3;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_OP1   = 3'd1,
    SRC_OP2   = 3'd2,
    SRC_RES   = 3'd3,
    SRC_SHIFT = 3'd4,
    SRC_BIT   = 3'd5
  } busSrcT;

  typedef enum logic [1:0] {
    LD_HOLD = 2'd0,
    LD_BUS  = 2'd1,
    LD_ALT  = 2'd2,
    LD_ZERO = 2'd3
  } loadT;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_AND = 2'd1,
    OP_OR  = 2'd2,
    OP_XOR = 2'd3
  } aluOpT;

  typedef struct packed {
    logic  drvOp1;
    logic  drvOp2;
    logic  drvRes;
    logic  drvShift;
    logic  drvBit;
    logic  ldOp1Bus;
    logic  ldOp1Low;
    logic  ldOp1Zero;
    logic  ldOp2Bus;
    logic  ldOp2Alt;
    logic  ldOp2Zero;
    logic  wrLow;
    logic  wrHigh;
    aluOpT op;
    logic  ovfEn;
  } strobeT;
endpackage

// File: rtl/nibAluCtrl.sv
module nibAluCtrl
  import nibAluPkg::*;
(
  input  logic [2:0] busSrc,
  input  logic [1:0] op1Sel,
  input  logic [1:0] op2Sel,
  input  logic       passLow,
  input  logic       passHigh,
  input  logic       opR,
  input  logic       opS,
  input  logic       opV,
  output strobeT     strobe
);
  always_comb begin
    strobe = '0;
    case (busSrc)
      SRC_OP1:   strobe.drvOp1   = 1'b1;
      SRC_OP2:   strobe.drvOp2   = 1'b1;
      SRC_RES:   strobe.drvRes   = 1'b1;
      SRC_SHIFT: strobe.drvShift = 1'b1;
      SRC_BIT:   strobe.drvBit   = 1'b1;
      default:   ;
    endcase
    case (op1Sel)
      LD_BUS:  strobe.ldOp1Bus  = 1'b1;
      LD_ALT:  strobe.ldOp1Low  = 1'b1;
      LD_ZERO: strobe.ldOp1Zero = 1'b1;
      default: ;
    endcase
    case (op2Sel)
      LD_BUS:  strobe.ldOp2Bus  = 1'b1;
      LD_ALT:  strobe.ldOp2Alt  = 1'b1;
      LD_ZERO: strobe.ldOp2Zero = 1'b1;
      default: ;
    endcase
    strobe.wrLow  = passLow;
    strobe.wrHigh = passHigh & ~passLow;
    strobe.op     = aluOpT'({opS, opR});
    strobe.ovfEn  = opV;
  end
endmodule

// File: rtl/nibAluPath.sv
module nibAluPath
  import nibAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [BYTE_W-1:0] extRead,
  input  logic [BYTE_W-1:0] altIn,
  input  logic              shiftRight,
  input  logic              shiftLeft,
  input  logic              shiftIn,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              passLow,
  input  logic              highSel,
  input  logic              negOp2,
  input  logic              coreCin,
  input  logic              parityIn,
  output logic [BYTE_W-1:0] intBus,
  output logic              shiftBit0,
  output logic              shiftBit7,
  output logic              cfOut,
  output logic              vfOut,
  output logic              parityOut,
  output logic              zeroOut,
  output logic              signOut,
  output logic              yfOut,
  output logic              xfOut,
  output logic              lowGt9,
  output logic              highGt9,
  output logic              highEq9
);
  localparam int SUM_W = NIB_W + 1;

  logic [BYTE_W-1:0] op1Q, op2Q, shiftVal, bitVal;
  logic [NIB_W-1:0]  resLowQ, resHighQ, aNib, bRaw, bNib, coreRes;
  logic [SUM_W-1:0]  fullSum;
  logic [NIB_W-1:0]  partSum;
  logic              carryTop;

  // Input stage: shifter and one-hot bit generator
  always_comb begin
    if (shiftRight)     shiftVal = {shiftIn, extRead[BYTE_W-1:1]};
    else if (shiftLeft) shiftVal = {extRead[BYTE_W-2:0], shiftIn};
    else                shiftVal = extRead;
  end
  assign shiftBit0 = extRead[0];
  assign shiftBit7 = extRead[BYTE_W-1];
  assign bitVal    = BYTE_W'(1) << bitIdx;

  // Single-driver internal bus
  always_comb begin
    intBus = '0;
    if (strobe.drvOp1)   intBus = op1Q;
    if (strobe.drvOp2)   intBus = op2Q;
    if (strobe.drvRes)   intBus = {resHighQ, resLowQ};
    if (strobe.drvShift) intBus = shiftVal;
    if (strobe.drvBit)   intBus = bitVal;
  end

  // Operand latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Q <= '0;
      op2Q <= '0;
    end else begin
      if (strobe.ldOp1Bus)       op1Q <= intBus;
      else if (strobe.ldOp1Low)  op1Q <= {{NIB_W{1'b0}}, intBus[NIB_W-1:0]};
      else if (strobe.ldOp1Zero) op1Q <= '0;
      if (strobe.ldOp2Bus)       op2Q <= intBus;
      else if (strobe.ldOp2Alt)  op2Q <= altIn;
      else if (strobe.ldOp2Zero) op2Q <= '0;
    end
  end

  // Four-bit core
  assign aNib = passLow ? op1Q[NIB_W-1:0] : op1Q[BYTE_W-1:NIB_W];
  assign bRaw = highSel ? op2Q[BYTE_W-1:NIB_W] : op2Q[NIB_W-1:0];
  assign bNib = negOp2 ? ~bRaw : bRaw;
  assign fullSum = {1'b0, aNib} + {1'b0, bNib} + SUM_W'(coreCin);
  assign partSum = {1'b0, aNib[NIB_W-2:0]} + {1'b0, bNib[NIB_W-2:0]} + NIB_W'(coreCin);
  assign carryTop = partSum[NIB_W-1];

  always_comb begin
    cfOut = 1'b0;
    case (strobe.op)
      OP_ADD: begin
        coreRes = fullSum[NIB_W-1:0];
        cfOut   = fullSum[NIB_W];
      end
      OP_AND:  coreRes = aNib & bNib;
      OP_OR:   coreRes = aNib | bNib;
      default: coreRes = aNib ^ bNib;
    endcase
  end
  assign vfOut = strobe.ovfEn & (strobe.op == OP_ADD) & (carryTop ^ fullSum[NIB_W]);

  // Result latch, one nibble per pass
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resLowQ  <= '0;
      resHighQ <= '0;
    end else begin
      if (strobe.wrLow)  resLowQ  <= coreRes;
      if (strobe.wrHigh) resHighQ <= coreRes;
    end
  end

  // Flags and decimal-adjust compares
  assign parityOut = ~((~^coreRes) ^ parityIn);
  assign zeroOut   = (resLowQ == '0) && (coreRes == '0);
  assign signOut   = coreRes[NIB_W-1];
  assign yfOut     = coreRes[YF_POS-NIB_W];
  assign xfOut     = resLowQ[XF_POS];
  assign lowGt9    = resLowQ > NIB_W'(DEC_MAX);
  assign highGt9   = coreRes > NIB_W'(DEC_MAX);
  assign highEq9   = coreRes == NIB_W'(DEC_MAX);
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nibAluPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  inout  wire  [7:0] extBus,
  input  logic       extOe,
  input  logic [2:0] busSrc,
  input  logic [1:0] op1Sel,
  input  logic [1:0] op2Sel,
  input  logic [7:0] altIn,
  input  logic       shiftRight,
  input  logic       shiftLeft,
  input  logic       shiftIn,
  output logic       shiftBit0,
  output logic       shiftBit7,
  input  logic [2:0] bitIdx,
  input  logic       passLow,
  input  logic       passHigh,
  input  logic       highSel,
  input  logic       negOp2,
  input  logic       coreCin,
  input  logic       opR,
  input  logic       opS,
  input  logic       opV,
  input  logic       parityIn,
  output logic       cfOut,
  output logic       vfOut,
  output logic       parityOut,
  output logic       zeroOut,
  output logic       signOut,
  output logic       yfOut,
  output logic       xfOut,
  output logic       lowGt9,
  output logic       highGt9,
  output logic       highEq9
);
  strobeT            strobe;
  logic [BYTE_W-1:0] intBus;
  logic [BYTE_W-1:0] extRead;

  assign extBus  = extOe ? intBus : {BYTE_W{1'bz}};
  assign extRead = extOe ? '0 : extBus;

  nibAluCtrl ctrl (
    .busSrc(busSrc), .op1Sel(op1Sel), .op2Sel(op2Sel),
    .passLow(passLow), .passHigh(passHigh),
    .opR(opR), .opS(opS), .opV(opV), .strobe(strobe)
  );

  nibAluPath path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .extRead(extRead), .altIn(altIn),
    .shiftRight(shiftRight), .shiftLeft(shiftLeft), .shiftIn(shiftIn),
    .bitIdx(bitIdx), .passLow(passLow), .highSel(highSel), .negOp2(negOp2),
    .coreCin(coreCin), .parityIn(parityIn), .intBus(intBus),
    .shiftBit0(shiftBit0), .shiftBit7(shiftBit7), .cfOut(cfOut), .vfOut(vfOut),
    .parityOut(parityOut), .zeroOut(zeroOut), .signOut(signOut), .yfOut(yfOut),
    .xfOut(xfOut), .lowGt9(lowGt9), .highGt9(highGt9), .highEq9(highEq9)
  );
endmodule

// File: rtl/nibAluChecker.sv
module nibAluChecker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] extBus,
  input logic       extOe,
  input logic [2:0] busSrc,
  input logic [1:0] op1Sel,
  input logic       opR,
  input logic       opS,
  input logic       cfOut,
  input logic       zeroOut,
  input logic       signOut,
  input logic       yfOut,
  input logic       xfOut,
  input logic       highGt9,
  input logic       highEq9
);
  a_r6_bit_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (extOe && busSrc == 3'd5) |-> $onehot(extBus));

  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    (extOe && busSrc == 3'd0) |-> (extBus == 8'h00));

  a_r8_logic_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opR || opS) |-> !cfOut);

  a_r11_zero_clears_bits: assert property (@(posedge clk) disable iff (!rstN)
    zeroOut |-> (!signOut && !yfOut && !xfOut));

  a_r12_nine_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    highEq9 |-> !highGt9);

  a_r3_op1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (extOe && busSrc == 3'd1 && op1Sel == 2'd0) |=>
      (!(extOe && busSrc == 3'd1) || $stable(extBus)));
endmodule

bind nibble_alu nibAluChecker chk (
  .clk(clk), .rstN(rstN), .extBus(extBus), .extOe(extOe), .busSrc(busSrc),
  .op1Sel(op1Sel), .opR(opR), .opS(opS), .cfOut(cfOut), .zeroOut(zeroOut),
  .signOut(signOut), .yfOut(yfOut), .xfOut(xfOut), .highGt9(highGt9),
  .highEq9(highEq9)
);

// File: tb/nibble_alu_test.sv
`timescale 1ns/1ps
module nibble_alu_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tbEn = 1'b0;
  logic [7:0] tbDrv = 8'h00;
  wire  [7:0] extBus;
  logic extOe = 0, shiftRight = 0, shiftLeft = 0, shiftIn = 0;
  logic [2:0] busSrc = 0, bitIdx = 0;
  logic [1:0] op1Sel = 0, op2Sel = 0;
  logic [7:0] altIn = 0;
  logic passLow = 0, passHigh = 0, highSel = 0, negOp2 = 0, coreCin = 0;
  logic opR = 0, opS = 0, opV = 0, parityIn = 0;
  logic shiftBit0, shiftBit7, cfOut, vfOut, parityOut, zeroOut, signOut;
  logic yfOut, xfOut, lowGt9, highGt9, highEq9;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign extBus = tbEn ? tbDrv : 8'bz;
  always #4 clk = ~clk;

  nibble_alu uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    tbEn = 0; extOe = 0; busSrc = 0; op1Sel = 0; op2Sel = 0;
    shiftRight = 0; shiftLeft = 0; shiftIn = 0; passLow = 0; passHigh = 0;
    highSel = 0; negOp2 = 0; coreCin = 0; opR = 0; opS = 0; opV = 0; parityIn = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic readBus(input logic [2:0] src, output logic [7:0] v);
    tbEn = 0; extOe = 1; busSrc = src;
    @(negedge clk); v = extBus;
    tick(); idle();
  endtask

  task automatic loadByte(input bit second, input logic [7:0] v, input logic [1:0] sel);
    tbEn = 1; tbDrv = v; busSrc = 3'd4;
    if (second) op2Sel = sel; else op1Sel = sel;
    tick(); idle();
  endtask

  // op: 0 add, 1 and, 2 or, 3 xor
  task automatic runOp(input logic [7:0] a, input logic [7:0] b, input int op,
                       input bit neg, input bit cin0, input bit v);
    logic hc, pl, cf, vf, par, zf, sf, yf, xf, lg, hg, he;
    logic [7:0] got, bb, r;
    int sum;
    bit ovf;
    loadByte(0, a, 2'd1);
    loadByte(1, b, 2'd1);
    opR = op[0]; opS = op[1]; opV = v; negOp2 = neg;
    passLow = 1; highSel = 0; coreCin = cin0; parityIn = 1;
    @(negedge clk); hc = cfOut; pl = parityOut;
    tick();
    opR = op[0]; opS = op[1]; opV = v; negOp2 = neg;
    passLow = 0; passHigh = 1; highSel = 1; coreCin = hc; parityIn = pl;
    @(negedge clk);
    cf = cfOut; vf = vfOut; par = parityOut; zf = zeroOut; sf = signOut;
    yf = yfOut; xf = xfOut; lg = lowGt9; hg = highGt9; he = highEq9;
    tick(); idle();
    readBus(3'd3, got);
    bb = neg ? ~b : b;
    sum = int'(a) + int'(bb) + int'(cin0);
    case (op)
      0: r = sum[7:0];
      1: r = a & bb;
      2: r = a | bb;
      default: r = a ^ bb;
    endcase
    ovf = (op == 0) && v && (a[7] == bb[7]) && (r[7] != a[7]);
    chk(got == r, "R7/R8 result", got, r);
    chk(hc == ((op == 0) ? (int'(a[3:0]) + int'(bb[3:0]) + int'(cin0) > 15) : 1'b0),
        "R7 half carry", hc, 0);
    chk(cf == ((op == 0) ? sum[8] : 1'b0), "R7/R8 carry", cf, sum[8]);
    chk(vf == ovf, "R9 overflow", vf, ovf);
    chk(par == ~^r, "R10 parity", par, ~^r);
    chk(zf == (r == 0), "R11 zero", zf, r == 0);
    chk({sf, yf, xf} == {r[7], r[5], r[3]}, "R11 sign/copies", {sf, yf, xf}, {r[7], r[5], r[3]});
    chk({lg, hg, he} == {r[3:0] > 9, r[7:4] > 9, r[7:4] == 9}, "R12 decimal compares",
        {lg, hg, he}, {r[3:0] > 9, r[7:4] > 9, r[7:4] == 9});
  endtask

  initial begin
    #1520000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, e;
    idle();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // R1 reset state
    readBus(3'd1, v); chk(v == 0, "R1 op1 reset", v, 0);
    readBus(3'd2, v); chk(v == 0, "R1 op2 reset", v, 0);
    readBus(3'd3, v); chk(v == 0, "R1 result reset", v, 0);
    // R2 idle codes and undriven read-back
    for (int s = 0; s < 8; s++) begin
      if (s == 0 || s > 5) begin
        readBus(3'(s), v); chk(v == 0, "R2 idle code", v, 0);
      end
    end
    tbEn = 1; tbDrv = 8'hA5; @(negedge clk);
    chk(extBus == 8'hA5, "R2 not driven when extOe low", extBus, 8'hA5);
    tick(); idle();
    // R5 shifter sweep
    for (int x = 0; x < 256; x++) begin
      for (int m = 0; m < 3; m++) begin
        for (int si = 0; si < 2; si++) begin
          tbEn = 1; tbDrv = 8'(x); busSrc = 3'd4; op1Sel = 2'd1;
          shiftRight = (m == 1); shiftLeft = (m >= 1); shiftIn = si[0];
          @(negedge clk);
          chk({shiftBit7, shiftBit0} == {tbDrv[7], tbDrv[0]}, "R5 edge bits",
              {shiftBit7, shiftBit0}, {tbDrv[7], tbDrv[0]});
          tick(); idle();
          readBus(3'd1, v);
          e = (m == 1) ? {si[0], tbDrv[7:1]} : (m == 2) ? {tbDrv[6:0], si[0]} : tbDrv;
          chk(v == e, "R5 shifter", v, e);
        end
      end
    end
    // R6 bit selector, direct and through operand 2
    for (int i = 0; i < 8; i++) begin
      bitIdx = 3'(i);
      readBus(3'd5, v); chk(v == (8'h1 << i), "R6 bit select", v, 8'h1 << i);
      bitIdx = 3'(i); busSrc = 3'd5; op2Sel = 2'd1; tick(); idle();
      readBus(3'd2, v); chk(v == (8'h1 << i), "R6 bit into op2", v, 8'h1 << i);
    end
    // R3 operand 1 sources
    loadByte(0, 8'h5C, 2'd2); readBus(3'd1, v); chk(v == 8'h0C, "R3 low nibble", v, 8'h0C);
    loadByte(0, 8'hE7, 2'd1); loadByte(0, 8'h11, 2'd0);
    readBus(3'd1, v); chk(v == 8'hE7, "R3 hold", v, 8'hE7);
    readBus(3'd1, v); chk(v == 8'hE7, "R3 hold repeat", v, 8'hE7);
    op1Sel = 2'd3; tick(); idle(); readBus(3'd1, v); chk(v == 0, "R3 zero", v, 0);
    // R4 operand 2 sources
    altIn = 8'h3B; op2Sel = 2'd2; tick(); idle(); altIn = 8'hFF;
    readBus(3'd2, v); chk(v == 8'h3B, "R4 alternate", v, 8'h3B);
    loadByte(1, 8'h99, 2'd0); readBus(3'd2, v); chk(v == 8'h3B, "R4 hold", v, 8'h3B);
    op2Sel = 2'd3; tick(); idle(); readBus(3'd2, v); chk(v == 0, "R4 zero", v, 0);
    // R7 named case
    runOp(8'h8C, 8'h68, 0, 0, 0, 1);
    readBus(3'd3, v); chk(v == 8'hF4, "R7 8C+68", v, 8'hF4);
    // R7/R9 add sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 11) runOp(8'(a), 8'(b), 0, 0, 0, 1);
    // R7/R9 subtraction by complement with carry-in 1
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5) runOp(8'(a), 8'(b), 0, 1, 1, 1);
    // R8 logic operations, overflow enable set (R9 must stay clear)
    for (int op = 1; op < 4; op++)
      for (int a = 0; a < 256; a += 7)
        for (int b = 0; b < 256; b += 5) runOp(8'(a), 8'(b), op, b[0], 0, 1);
    // R9 overflow disabled
    runOp(8'h7F, 8'h01, 0, 0, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule